// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit for a datapath that executes each instruction over several clock cycles, re-using one ALU and one memory port. It handles five instruction kinds: register-register arithmetic, word load, word store, branch-if-equal and unconditional jump. The unit holds a 4-bit step register with ten legal states. A fixed table, indexed only by the current state, produces the control word that steers the datapath. The datapath, the ALU function decoder and the memory sit outside the block.

The 6-bit opcode from the instruction register affects only the choice of the next state, and only at two points. The first is the decode step, which selects the execution path. The second is the address step, which picks load or store. Instructions take between three cycles (branch, jump) and five cycles (load). An opcode outside the supported set, seen at either choice point, sends the unit back to fetch. It also raises a flag that stays set until reset.

The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer, so the unit stays in fetch for two more clock edges after the pin rises.

Top module: `seq_ctrl_unit`

## Requirements
- R1: While rst_n is low the unit is in state 0 (fetch control word) and illegal is 0, taking effect without waiting for a clock edge. After rst_n rises, the state stays 0 for exactly two further rising edges and moves to decode on the third.
- R2: State 0 (fetch) drives mem_rd=1, ir_wr=1, pc_wr=1, addr_sel=0, alu_a_sel=0, alu_b_sel=01, alu_op=00 and pc_src=00, with every other output 0. It always moves to state 1.
- R3: State 1 (decode) drives alu_b_sel=11 with every other control output 0. The next state is chosen by opcode: 000000 goes to state 6, 000010 goes to state 9, 000100 goes to state 8, and 100011 or 101011 goes to state 2.
- R4: State 2 (address) drives alu_a_sel=1 and alu_b_sel=10, all else 0. It goes to state 3 if the opcode in that same cycle is 100011, and to state 5 if it is 101011.
- R5: State 3 drives mem_rd=1 and addr_sel=1, then moves to state 4. State 4 drives rf_wr=1, wb_sel=1 and rf_dst_sel=0, then moves to state 0. A load takes five cycles.
- R6: State 5 drives mem_wr=1 and addr_sel=1, then moves to state 0. A store takes four cycles.
- R7: State 6 drives alu_a_sel=1, alu_b_sel=00 and alu_op=10, then moves to state 7. State 7 drives rf_wr=1, rf_dst_sel=1 and wb_sel=0, then moves to state 0.
- R8: State 8 drives alu_a_sel=1, alu_op=01, pc_wr_cond=1 and pc_src=01, then moves to state 0.
- R9: State 9 drives pc_wr=1 and pc_src=10, then moves to state 0.
- R10: An opcode outside the supported set in state 1, or anything other than 100011 or 101011 in state 2, sends the unit to state 0. From the next cycle on, illegal reads 1 and stays 1 through later legal instructions until reset.
- R11: Every output that a state does not assign reads 0, so pc_wr, ir_wr, mem_wr and rf_wr are 0 outside their states and mem_rd and mem_wr are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized |
| opcode | input | 6 | Opcode field of the held instruction |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write qualified by ALU zero |
| addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| wb_sel | output | 1 | Register write data: 0 ALU result, 1 memory data register |
| pc_src | output | 2 | Next PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU first operand: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU second operand: 00 B, 01 constant 4, 10 extended, 11 extended shifted |
| rf_wr | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination register field: 0 rt, 1 rd |
| illegal | output | 1 | Sticky unsupported-opcode flag |

## Verification
The hardest situation to reach is an illegal opcode detected in the address step. A stable opcode that passed decode as a load or store always dispatches cleanly there. To reach it, the stimulus presents a load opcode through decode and then replaces it with an unsupported code in the cycle the unit sits in the address step. The same mid-instruction swap, from load to store, shows that the second dispatch reads the opcode of its own cycle. A reset is applied in the middle of the run to show that it clears the sticky flag before this case is exercised.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

  localparam int OPC_W   = 6;
  localparam int STATE_W = 4;

  // State numbering is part of the behaviour (fetch is 0, decode is 1, ...)
  typedef enum logic [STATE_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_MEMRD  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_MEMWR  = 4'd5,
    ST_EXEC   = 4'd6,
    ST_ALUWB  = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } step_t;

  localparam logic [OPC_W-1:0] OPC_ALU   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       wb_sel;
    logic [1:0] pc_src;
    logic [1:0] alu_op;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_wr;
    logic       rf_dst_sel;
  } ctrl_word_t;

endpackage

// File: rtl/seqctl_rst_sync.sv
module seqctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  generate
    if (STAGES < 2) begin : g_single
      logic flop_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flop_q <= 1'b0;
        else        flop_q <= 1'b1;
      end
      assign srst_n = flop_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
      assign srst_n = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/seqctl_next_state.sv
module seqctl_next_state
  import seqctl_pkg::*;
(
  input  step_t            cur,
  input  logic [OPC_W-1:0] opcode,
  output step_t            nxt,
  output logic             bad_op
);

  always_comb begin
    nxt    = ST_FETCH;
    bad_op = 1'b0;
    unique case (cur)
      ST_FETCH: nxt = ST_DECODE;
      ST_DECODE: begin
        // first dispatch: choose execution path by opcode
        if      (opcode == OPC_ALU)                          nxt = ST_EXEC;
        else if (opcode == OPC_JUMP)                         nxt = ST_JUMP;
        else if (opcode == OPC_BEQ)                          nxt = ST_BRANCH;
        else if (opcode == OPC_LOAD || opcode == OPC_STORE)  nxt = ST_ADDR;
        else                                                 bad_op = 1'b1;
      end
      ST_ADDR: begin
        // second dispatch: load or store, opcode of this very cycle
        if      (opcode == OPC_LOAD)  nxt = ST_MEMRD;
        else if (opcode == OPC_STORE) nxt = ST_MEMWR;
        else                          bad_op = 1'b1;
      end
      ST_MEMRD: nxt = ST_LDWB;
      ST_EXEC:  nxt = ST_ALUWB;
      default:  nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/seqctl_ctrl_decode.sv
module seqctl_ctrl_decode
  import seqctl_pkg::*;
(
  input  step_t      cur,
  output ctrl_word_t cw
);

  always_comb begin
    cw = '0;  // unassigned controls are driven low
    unique case (cur)
      ST_FETCH: begin
        cw.mem_rd    = 1'b1;
        cw.ir_wr     = 1'b1;
        cw.pc_wr     = 1'b1;
        cw.alu_b_sel = 2'b01;
      end
      ST_DECODE: cw.alu_b_sel = 2'b11;
      ST_ADDR: begin
        cw.alu_a_sel = 1'b1;
        cw.alu_b_sel = 2'b10;
      end
      ST_MEMRD: begin
        cw.mem_rd   = 1'b1;
        cw.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        cw.rf_wr  = 1'b1;
        cw.wb_sel = 1'b1;
      end
      ST_MEMWR: begin
        cw.mem_wr   = 1'b1;
        cw.addr_sel = 1'b1;
      end
      ST_EXEC: begin
        cw.alu_a_sel = 1'b1;
        cw.alu_op    = 2'b10;
      end
      ST_ALUWB: begin
        cw.rf_wr      = 1'b1;
        cw.rf_dst_sel = 1'b1;
      end
      ST_BRANCH: begin
        cw.alu_a_sel  = 1'b1;
        cw.alu_op     = 2'b01;
        cw.pc_wr_cond = 1'b1;
        cw.pc_src     = 2'b01;
      end
      ST_JUMP: begin
        cw.pc_wr  = 1'b1;
        cw.pc_src = 2'b10;
      end
      default: cw = '0;
    endcase
  end

endmodule

// File: rtl/seq_ctrl_unit.sv
module seq_ctrl_unit
  import seqctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic             addr_sel,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_wr,
  output logic             wb_sel,
  output logic [1:0]       pc_src,
  output logic [1:0]       alu_op,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic             rf_wr,
  output logic             rf_dst_sel,
  output logic             illegal
);

  logic       srst_n;
  step_t      state_q;
  step_t      state_d;
  logic       bad_op;
  logic       illegal_q;
  ctrl_word_t cw;

  seqctl_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  seqctl_next_state u_next (
    .cur    (state_q),
    .opcode (opcode),
    .nxt    (state_d),
    .bad_op (bad_op)
  );

  seqctl_ctrl_decode u_dec (
    .cur (state_q),
    .cw  (cw)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     illegal_q <= 1'b0;
    else if (bad_op) illegal_q <= 1'b1;
  end

  assign pc_wr      = cw.pc_wr;
  assign pc_wr_cond = cw.pc_wr_cond;
  assign addr_sel   = cw.addr_sel;
  assign mem_rd     = cw.mem_rd;
  assign mem_wr     = cw.mem_wr;
  assign ir_wr      = cw.ir_wr;
  assign wb_sel     = cw.wb_sel;
  assign pc_src     = cw.pc_src;
  assign alu_op     = cw.alu_op;
  assign alu_a_sel  = cw.alu_a_sel;
  assign alu_b_sel  = cw.alu_b_sel;
  assign rf_wr      = cw.rf_wr;
  assign rf_dst_sel = cw.rf_dst_sel;
  assign illegal    = illegal_q;

  // R2: fetch always hands over to decode
  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (!srst_n)
    state_q == ST_FETCH |=> state_q == ST_DECODE);

  // R8: a branch opcode in decode yields a conditional PC write next cycle
  p_beq_cond_write_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == ST_DECODE && opcode == OPC_BEQ) |=> (pc_wr_cond && pc_src == 2'b01));

  // R5: memory read step is followed by load write-back
  p_load_chain_r5: assert property (@(posedge clk) disable iff (!srst_n)
    state_q == ST_MEMRD |=> (rf_wr && wb_sel));

  // R10: flag stays set once raised
  p_illegal_sticky_r10: assert property (@(posedge clk) disable iff (!srst_n)
    illegal |=> illegal);

  // R10: flag can only rise after a dispatch step
  p_illegal_origin_r10: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(illegal) |-> ($past(state_q) == ST_DECODE || $past(state_q) == ST_ADDR));

  // R11: the memory port never reads and writes at once
  p_mem_exclusive_r11: assert property (@(posedge clk) disable iff (!srst_n)
    !(mem_rd && mem_wr));

  // R11: at most one of the register-file and memory write strobes
  p_single_write_r11: assert property (@(posedge clk) disable iff (!srst_n)
    $countones({mem_wr, rf_wr}) <= 1);

endmodule

// File: tb/sim_seq_ctrl_unit.sv
module sim_seq_ctrl_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'b000000;
  logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel;
  logic [1:0] pc_src, alu_op, alu_b_sel;
  logic       alu_a_sel, rf_wr, rf_dst_sel, illegal;

  always #5 clk = ~clk;

  seq_ctrl_unit u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_sel(wb_sel),
    .pc_src(pc_src), .alu_op(alu_op), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel),
    .illegal(illegal)
  );

  typedef struct packed {
    logic [3:0] st;
    logic       ill;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  logic sticky = 1'b0;

  // observed word: pc_wr,pc_wr_cond,addr_sel,mem_rd,mem_wr,ir_wr,wb_sel,
  // pc_src[1:0],alu_op[1:0],alu_a_sel,alu_b_sel[1:0],rf_wr,rf_dst_sel
  function automatic logic [15:0] seen();
    return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel,
            pc_src, alu_op, alu_a_sel, alu_b_sel, rf_wr, rf_dst_sel};
  endfunction

  function automatic logic [15:0] want(input logic [3:0] s);
    logic [15:0] w;
    w = '0;
    case (s)
      4'd0: begin w[15] = 1; w[12] = 1; w[10] = 1; w[3:2] = 2'b01; end
      4'd1: w[3:2] = 2'b11;
      4'd2: begin w[4] = 1; w[3:2] = 2'b10; end
      4'd3: begin w[12] = 1; w[13] = 1; end
      4'd4: begin w[1] = 1; w[9] = 1; end
      4'd5: begin w[11] = 1; w[13] = 1; end
      4'd6: begin w[4] = 1; w[6:5] = 2'b10; end
      4'd7: begin w[1] = 1; w[0] = 1; end
      4'd8: begin w[4] = 1; w[6:5] = 2'b01; w[14] = 1; w[8:7] = 2'b01; end
      4'd9: begin w[15] = 1; w[8:7] = 2'b10; end
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3, 4'd4: return "R5";
      4'd5: return "R6";
      4'd6, 4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops one expected step per cycle and compares (R11 covered by full-word compare)
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(req_of(e.st), seen(), want(e.st));
      check("R10", {15'd0, illegal}, {15'd0, e.ill});
    end
  end

  task automatic drain();
    while (q.size() != 0) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
  endtask

  // driver: called one ns after an edge that left the unit in fetch
  task automatic issue(input logic [5:0] op, input int n,
                       input int p0, input int p1, input int p2, input int p3, input int p4);
    int p[5];
    p = '{p0, p1, p2, p3, p4};
    opcode = op;
    for (int i = 0; i < n; i++) q.push_back({p[i][3:0], sticky});
    drain();
  endtask

  // opcode swapped while the unit sits in the address step
  task automatic issue_swap(input logic [5:0] op1, input logic [5:0] op2, input int n,
                            input int p3);
    int p[4];
    p = '{0, 1, 2, p3};
    opcode = op1;
    for (int i = 0; i < n; i++) q.push_back({p[i][3:0], sticky});
    @(posedge clk); #1;
    @(posedge clk); #1;
    opcode = op2;
    drain();
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    #2;
    check("R1", seen(), want(4'd0));
    check("R1", {15'd0, illegal}, 16'd0);
    @(negedge clk);
    check("R1", seen(), want(4'd0));
    @(posedge clk); #1;
    rst_n = 1'b1;
    sticky = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", seen(), want(4'd0));   // still held in fetch by release sync
    @(posedge clk); #1;
  endtask

  initial begin
    #(20000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1;
    check("R1", seen(), want(4'd0));
    check("R1", {15'd0, illegal}, 16'd0);
    do_reset();
    issue(6'b000000, 4, 0, 1, 6, 7, 0);  // R7 arithmetic, 4 cycles
    issue(6'b100011, 5, 0, 1, 2, 3, 4);  // R5 load, 5 cycles
    issue(6'b101011, 4, 0, 1, 2, 5, 0);  // R6 store
    issue(6'b000100, 3, 0, 1, 8, 0, 0);  // R8 branch
    issue(6'b000010, 3, 0, 1, 9, 0, 0);  // R9 jump
    issue_swap(6'b100011, 6'b101011, 4, 5); // R4 second dispatch reads current opcode
    issue(6'b001000, 2, 0, 1, 0, 0, 0);  // R10 illegal at decode
    sticky = 1'b1;
    issue(6'b000000, 4, 0, 1, 6, 7, 0);  // R10 flag persists across legal work
    issue(6'b111111, 2, 0, 1, 0, 0, 0);  // R10 second illegal, flag unchanged
    do_reset();                          // R1 clears flag
    issue(6'b000010, 3, 0, 1, 9, 0, 0);
    issue_swap(6'b100011, 6'b000000, 3, 0); // R10 illegal at address step
    sticky = 1'b1;
    issue(6'b101011, 4, 0, 1, 2, 5, 0);
    issue(6'b100011, 5, 0, 1, 2, 3, 4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule